// File: doc/BRIEF.md
# Direct-Mapped Branch Target Cache

This block sits beside the program-counter register of an instruction fetch stage and predicts simple direct branches. It keeps a direct-mapped table. Each slot holds the word address of a branch instruction and the word address of its target. An execution stage resolves simple branches and reports them through an update port. Every report rewrites the slot chosen by the branch address, and the slot's valid bit records whether the branch was taken.

To keep the table read off the critical path, the lookup runs two instructions ahead. In each accepted fetch cycle the slot for the current fetch address plus 8 is read and held for two accepted fetches. If fetch has meanwhile advanced sequentially to that address, a match raises a redirect toward the stored target. The same strobe marks the fetched instruction as predicted taken, so the downstream static predictor leaves it alone. Any jump in fetch empties this two-deep lookahead, whether it comes from outside or from the cache's own redirect. A build parameter can remove the cache entirely.

Top module: `branch_target_cache`

## Requirements
- R1: Reset clears every valid bit and empties the lookahead. No redirect is raised until a taken branch has been recorded after the reset.
- R2: The table is direct-mapped. Slot index = fetch/branch address bits [IDX_W+1:2], with IDX_W = log2(ENTRIES). An update overwrites whatever slot content shares its index.
- R3: An update with `updTaken`=1 makes its slot valid. An update with `updTaken`=0 rewrites the slot as invalid, so that branch no longer redirects.
- R4: A redirect needs all address bits above bit 1 of the fetch address to equal the stored branch address. A different address that maps to the same slot does not redirect.
- R5: On a redirect, `predTarget` carries the stored target. `predRedirect`, asserted in the same cycle as the fetched branch address, is also that instruction's predicted-taken flag.
- R6: After a fetch with `fetchJump`=1, or after a fetch the cache itself redirected, the first two accepted fetches (the jump destination and the next) never redirect. The third sequential fetch can.
- R7: A cycle with `fetchValid`=0 is a stall. It raises no redirect and leaves the lookahead unchanged, so prediction resumes as if the stall had not occurred.
- R8: If an update and a lookup read hit the same slot in one cycle, the lookup sees the slot's contents from before the update.
- R9: With `ENABLE`=0 the block never raises `predRedirect`.
- R10: Bits [1:0] of update and fetch addresses are neither stored nor compared. `predTarget` bits [1:0] are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchValid | input | 1 | Fetch accepts the address on `fetchAddr` this cycle |
| fetchAddr | input | ADDR_W | Address being fetched |
| fetchJump | input | 1 | `fetchAddr` was reached by an external redirect, not sequentially |
| updValid | input | 1 | A resolved simple branch is reported |
| updAddr | input | ADDR_W | Address of the resolved branch |
| updTarget | input | ADDR_W | Target of the resolved branch |
| updTaken | input | 1 | The resolved branch was taken |
| predRedirect | output | 1 | Redirect fetch to `predTarget`; current instruction is predicted taken |
| predTarget | output | ADDR_W | Predicted target address |

## Verification
The bench builds the cache with 16 slots and 32-bit addresses, so index bits [5:2] alias every 64 bytes. This makes eviction and tag-mismatch cases easy to reach with short code sequences. A second instance built with `ENABLE`=0 runs beside the first and sees the same stimulus on every cycle. The narrow table also lets the bench place an update on the exact cycle that reads the same slot. Short fetch runs started at 0, 4 and 8 bytes before a recorded branch cover the two-instruction blind window.

// File: rtl/btc_pkg.sv
package btc_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic adv;      // accepted fetch: read a slot, shift lookahead
    logic wr;       // write the slot addressed by the update port
    logic wrTaken;  // value written into that slot's valid bit
  } btcStrobe_t;

endpackage

// File: rtl/btc_ctrl.sv
module btc_ctrl
  import btc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       fetchValid,
  input  logic       fetchJump,
  input  logic       updValid,
  input  logic       updTaken,
  input  logic       tagMatch,
  output btcStrobe_t strb,
  output logic       hit
);

  logic stage1Ok;   // first lookahead stage holds a real read
  logic stage2Ok;   // second stage read is usable by the current fetch
  logic lastHit;    // previous accepted fetch was redirected by us
  logic jumpNow;

  assign jumpNow = fetchJump | lastHit;

  assign strb.adv     = fetchValid;
  assign strb.wr      = updValid;
  assign strb.wrTaken = updTaken;

  assign hit = fetchValid & ~jumpNow & stage2Ok & tagMatch;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1Ok <= 1'b0;
      stage2Ok <= 1'b0;
      lastHit  <= 1'b0;
    end else if (fetchValid) begin
      stage1Ok <= 1'b1;
      stage2Ok <= stage1Ok & ~jumpNow;
      lastHit  <= hit;
    end
  end

  // R6: the cycle after our own redirect cannot redirect again
  a_r6_no_back_to_back: assert property (@(posedge clk) disable iff (!rstN)
    hit |=> !hit);

  // R6: an external jump blanks the next cycle as well
  a_r6_jump_blanks_next: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && fetchJump) |=> !hit);

  // R7: a stall leaves the lookahead occupancy untouched
  a_r7_stall_holds_ok: assert property (@(posedge clk) disable iff (!rstN)
    !fetchValid |=> ($stable(stage2Ok) && $stable(stage1Ok) && $stable(lastHit)));

endmodule

// File: rtl/btc_datapath.sv
module btc_datapath
  import btc_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int ENTRIES = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  btcStrobe_t        strb,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic [ADDR_W-1:0] updAddr,
  input  logic [ADDR_W-1:0] updTarget,
  output logic              tagMatch,
  output logic [ADDR_W-1:0] lookTarget
);

  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0]  brMem [ENTRIES];
  logic [WORD_W-1:0]  tgMem [ENTRIES];
  logic [ENTRIES-1:0] vBits;

  logic [IDX_W-1:0] lookIdx;
  logic [IDX_W-1:0] wIdx;

  // lookahead stages: stage 1 is the raw read, stage 2 feeds the compare
  logic              s1V, s2V;
  logic [WORD_W-1:0] s1Br, s2Br, s1Tg, s2Tg;

  logic unusedLowBits;
  assign unusedLowBits = ^{fetchAddr[1:0], updAddr[1:0], updTarget[1:0]};

  assign lookIdx = IDX_W'((fetchAddr + ADDR_W'(8)) >> 2);
  assign wIdx    = IDX_W'(updAddr >> 2);

  // slot payload: no reset needed, guarded by the valid bits
  always_ff @(posedge clk) begin
    if (strb.wr) begin
      brMem[wIdx] <= updAddr[ADDR_W-1:2];
      tgMem[wIdx] <= updTarget[ADDR_W-1:2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)        vBits <= '0;
    else if (strb.wr) vBits[wIdx] <= strb.wrTaken;
  end

  // reads take the pre-write value when indices collide
  always_ff @(posedge clk) begin
    if (strb.adv) begin
      s1Br <= brMem[lookIdx];
      s1Tg <= tgMem[lookIdx];
      s2Br <= s1Br;
      s2Tg <= s1Tg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1V <= 1'b0;
      s2V <= 1'b0;
    end else if (strb.adv) begin
      s1V <= vBits[lookIdx];
      s2V <= s1V;
    end
  end

  assign tagMatch   = s2V && (s2Br == fetchAddr[ADDR_W-1:2]);
  assign lookTarget = {s2Tg, 2'b00};

  // R3: written valid bit follows the reported outcome
  a_r3_valid_follows_outcome: assert property (@(posedge clk) disable iff (!rstN)
    strb.wr |=> (vBits[$past(wIdx)] == $past(strb.wrTaken)));

  // R7: compare stage is frozen while fetch stalls
  a_r7_stall_freezes_stage: assert property (@(posedge clk) disable iff (!rstN)
    !strb.adv |=> ($stable(s2V) && $stable(s2Br) && $stable(s2Tg)));

endmodule

// File: rtl/branch_target_cache.sv
module branch_target_cache
  import btc_pkg::*;
#(
  parameter bit ENABLE  = 1'b1,
  parameter int ADDR_W  = 64,
  parameter int ENTRIES = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic              fetchJump,
  input  logic              updValid,
  input  logic [ADDR_W-1:0] updAddr,
  input  logic [ADDR_W-1:0] updTarget,
  input  logic              updTaken,
  output logic              predRedirect,
  output logic [ADDR_W-1:0] predTarget
);

  generate
    if (ENABLE) begin : g_on
      btcStrobe_t        strb;
      logic              tagMatch;
      logic              hit;
      logic [ADDR_W-1:0] lookTarget;

      btc_ctrl u_ctrl (
        .clk        (clk),
        .rstN       (rstN),
        .fetchValid (fetchValid),
        .fetchJump  (fetchJump),
        .updValid   (updValid),
        .updTaken   (updTaken),
        .tagMatch   (tagMatch),
        .strb       (strb),
        .hit        (hit)
      );

      btc_datapath #(
        .ADDR_W  (ADDR_W),
        .ENTRIES (ENTRIES)
      ) u_data (
        .clk        (clk),
        .rstN       (rstN),
        .strb       (strb),
        .fetchAddr  (fetchAddr),
        .updAddr    (updAddr),
        .updTarget  (updTarget),
        .tagMatch   (tagMatch),
        .lookTarget (lookTarget)
      );

      assign predRedirect = hit;
      assign predTarget   = hit ? lookTarget : '0;

      // R5: a redirect never points at a misaligned target
      a_r5_target_aligned: assert property (@(posedge clk) disable iff (!rstN)
        predRedirect |-> (predTarget[1:0] == 2'b00));
    end else begin : g_off
      logic unusedInputs;
      assign unusedInputs = ^{clk, rstN, fetchValid, fetchAddr, fetchJump,
                              updValid, updAddr, updTarget, updTaken};
      assign predRedirect = 1'b0;
      assign predTarget   = '0;
    end
  endgenerate

endmodule

// File: tb/tb_branch_target_cache.sv
module tb_branch_target_cache;

  localparam int AW = 32;
  localparam int NE = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          fetchValid = 1'b0;
  logic [AW-1:0] fetchAddr = '0;
  logic          fetchJump = 1'b0;
  logic          updValid = 1'b0;
  logic [AW-1:0] updAddr = '0;
  logic [AW-1:0] updTarget = '0;
  logic          updTaken = 1'b0;
  logic          predRedirect, offRedirect;
  logic [AW-1:0] predTarget, offTarget;

  always #2 clk = ~clk;

  branch_target_cache #(.ENABLE(1'b1), .ADDR_W(AW), .ENTRIES(NE)) dut (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchAddr(fetchAddr),
    .fetchJump(fetchJump), .updValid(updValid), .updAddr(updAddr),
    .updTarget(updTarget), .updTaken(updTaken),
    .predRedirect(predRedirect), .predTarget(predTarget));

  branch_target_cache #(.ENABLE(1'b0), .ADDR_W(AW), .ENTRIES(NE)) dutOff (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchAddr(fetchAddr),
    .fetchJump(fetchJump), .updValid(updValid), .updAddr(updAddr),
    .updTarget(updTarget), .updTaken(updTaken),
    .predRedirect(offRedirect), .predTarget(offTarget));

  int checks = 0;
  int fails  = 0;

  // scoreboard queues
  bit            qHit[$];
  logic [AW-1:0] qTgt[$];
  string         qReq[$];

  // reference model built from the requirements
  bit            mV[NE];
  logic [AW-3:0] mB[NE];
  logic [AW-3:0] mT[NE];
  bit            sn1V, sn2V;
  logic [AW-3:0] sn1B, sn2B, sn1T, sn2T;
  int            seqCnt;
  bit            mLastHit;
  bit            lastExp;
  logic [AW-1:0] lastTgt;

  function automatic int idxOf(input logic [AW-1:0] a);
    return int'(a[5:2]);
  endfunction

  task automatic modelReset();
    for (int i = 0; i < NE; i++) mV[i] = 1'b0;
    sn1V = 0; sn2V = 0; seqCnt = 0; mLastHit = 0;
  endtask

  // one cycle: optional fetch and optional update
  task automatic step(input bit fv, input logic [AW-1:0] fa, input bit fj,
                      input bit uv, input logic [AW-1:0] ua,
                      input logic [AW-1:0] ut, input bit utk, input string req);
    bit exp;
    logic [AW-1:0] la;
    @(negedge clk);
    fetchValid = fv; fetchAddr = fa; fetchJump = fj;
    updValid = uv; updAddr = ua; updTarget = ut; updTaken = utk;
    exp = 0;
    lastTgt = '0;
    if (fv && rstN) begin
      if (fj || mLastHit) seqCnt = 0; else seqCnt++;
      exp = (seqCnt >= 2) && sn2V && (sn2B == fa[AW-1:2]);
      if (exp) lastTgt = {sn2T, 2'b00};
      sn2V = sn1V; sn2B = sn1B; sn2T = sn1T;
      la = fa + 32'd8;
      sn1V = mV[idxOf(la)]; sn1B = mB[idxOf(la)]; sn1T = mT[idxOf(la)];
      mLastHit = exp;
    end
    if (uv && rstN) begin
      mV[idxOf(ua)] = utk; mB[idxOf(ua)] = ua[AW-1:2]; mT[idxOf(ua)] = ut[AW-1:2];
    end
    lastExp = exp;
    qHit.push_back(exp); qTgt.push_back(lastTgt); qReq.push_back(req);
  endtask

  task automatic fetch(input logic [AW-1:0] fa, input bit fj, input string req);
    step(1'b1, fa, fj, 1'b0, '0, '0, 1'b0, req);
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) step(1'b0, fetchAddr, 1'b0, 1'b0, '0, '0, 1'b0, req);
  endtask

  task automatic record(input logic [AW-1:0] ba, input logic [AW-1:0] ta,
                        input bit tk, input string req);
    step(1'b0, fetchAddr, 1'b0, 1'b1, ba, ta, tk, req);
  endtask

  // sequential run that follows predicted redirects
  task automatic run(input logic [AW-1:0] start, input int n, input string req);
    logic [AW-1:0] a;
    a = start;
    for (int i = 0; i < n; i++) begin
      fetch(a, (i == 0), req);
      a = lastExp ? lastTgt : a + 32'd4;
    end
  endtask

  task automatic doReset(input string req);
    @(negedge clk);
    rstN = 1'b0;
    modelReset();
    for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b0, 1'b0, '0, '0, 1'b0, req);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // monitor: compare away from the active edge
  always @(negedge clk) begin
    #1;
    if (qHit.size() > 0) begin
      bit e; logic [AW-1:0] t; string r;
      e = qHit.pop_front(); t = qTgt.pop_front(); r = qReq.pop_front();
      checks++;
      if (predRedirect !== e || (e && predTarget !== t)) begin
        fails++;
        $display("FAIL %s: redirect=%0b target=%h expected redirect=%0b target=%h",
                 r, predRedirect, predTarget, e, t);
      end
      checks++;
      if (offRedirect !== 1'b0) begin
        fails++;
        $display("FAIL R9: disabled redirect=%0b expected 0", offRedirect);
      end
    end
  end

  bit done = 0;

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    modelReset();
    doReset("R1");
    run(32'h1000, 8, "R1");                        // nothing recorded yet
    record(32'h1010, 32'h2000, 1'b1, "R3");
    run(32'h1000, 8, "R5");                        // hit at 0x1010 -> 0x2000
    run(32'h1008, 4, "R6");                        // third fetch hits
    run(32'h100C, 4, "R6");                        // second fetch: blind
    run(32'h1010, 3, "R6");                        // first fetch: blind
    run(32'h1048, 4, "R4");                        // 0x1050 aliases slot 4
    record(32'h1050, 32'h3000, 1'b1, "R2");        // evicts 0x1010
    run(32'h1000, 6, "R2");
    run(32'h1040, 7, "R2");                        // hit at 0x1050
    record(32'h1050, 32'h3000, 1'b0, "R3");        // not taken clears
    run(32'h1040, 7, "R3");
    // R8: update lands in the cycle that reads slot 6 for 0x1018
    fetch(32'h1008, 1'b1, "R8");
    fetch(32'h100C, 1'b0, "R8");
    step(1'b1, 32'h1010, 1'b0, 1'b1, 32'h1018, 32'h4000, 1'b1, "R8");
    fetch(32'h1014, 1'b0, "R8");
    fetch(32'h1018, 1'b0, "R8");                   // old contents: no hit
    run(32'h1008, 5, "R8");                        // now visible
    // R7: stalls between sequential fetches
    fetch(32'h1010, 1'b1, "R7");
    idle(3, "R7");
    fetch(32'h1014, 1'b0, "R7");
    idle(2, "R7");
    fetch(32'h1018, 1'b0, "R7");                   // predicted despite stalls
    idle(2, "R7");
    // R10: low address bits dropped on both sides
    record(32'h1023, 32'h5002, 1'b1, "R10");
    run(32'h1018, 5, "R10");
    doReset("R1");
    run(32'h1008, 6, "R1");                        // everything forgotten
    idle(3, "R1");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule